// File: doc/BRIEF.md
# Bring-up self-test sequencer

The sequencer is a smoke-test engine for board bring-up. One trigger pulse starts a fixed series of checks. The first writes and reads back a small internal memory. The next three run short known-answer datapaths: an integrator/comb pair, a sum/difference butterfly and a multiply-accumulate. The last captures a burst of samples from a 16-bit ADC stream. When the series ends, the block reports one pass flag per test and a detail byte that identifies the first failure.

During the ADC stage the block holds a capture-active output high. Each valid input sample is passed straight through to the capture outputs until the burst length is reached. If the stream stays silent, a timeout closes the stage so that the sequence always completes. Software or a bring-up script pulses the trigger, waits for result-valid, and then reads the flags.

Top module: `bist_sequencer`

## Requirements
- R1: After reset, busy_o and result_valid_o are low, and result_flags_o and result_detail_o are zero.
- R2: A trigger pulse accepted while idle makes busy_o high on the next clock cycle.
- R3: A healthy run ends with result_flags_o = 5'b11111 and result_detail_o = 0. The flag bits are assigned as follows: bit0 memory, bit1 integrator/comb, bit2 butterfly, bit3 multiply-accumulate, bit4 ADC capture.
- R4: The tests run in the order memory, integrator/comb, butterfly, multiply-accumulate, ADC. capture_active_o therefore rises no earlier than 2*2^RAM_AW + 3*KAT_STEPS cycles after the trigger.
- R5: While capture_active_o is high, every cycle with adc_valid_i high is forwarded: capture_valid_o goes high and capture_data_o equals adc_data_i. Exactly CAP_N samples are forwarded per run.
- R6: Sparse or irregular adc_valid_i, with gaps of several cycles, still completes the capture with flag bit4 set.
- R7: If fewer than CAP_N samples arrive within ADC_TMO cycles of the capture start, flag bit4 is cleared. result_detail_o is then {3'd4, 5'd2}, where bits [7:5] hold the index of the first failing test in execution order and bits [4:0] hold the sub-code (1 = datapath mismatch, 2 = ADC timeout).
- R8: On completion, result_valid_o goes high and busy_o goes low in the same cycle. A new trigger clears result_valid_o, and a second run produces the same results.
- R9: A trigger that arrives while busy_o is high is ignored. The run's latency and results are unchanged.
- R10: After CAP_N samples have been forwarded, capture_active_o is low, and further adc_valid_i pulses do not produce capture_valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trigger_i | input | 1 | Start pulse |
| busy_o | output | 1 | Sequence running |
| result_valid_o | output | 1 | Results available |
| result_flags_o | output | 5 | Per-test pass flags |
| result_detail_o | output | 8 | First-failure index and sub-code |
| adc_data_i | input | 16 | ADC sample |
| adc_valid_i | input | 1 | ADC sample strobe |
| capture_active_o | output | 1 | ADC capture window open |
| capture_data_o | output | 16 | Forwarded sample |
| capture_valid_o | output | 1 | Forwarded sample strobe |

## Verification
The internal known-answer stages always pass, so the only failure path that can be reached from the ports is the ADC timeout. The bench reaches it by keeping adc_valid_i low for a whole run. It then checks the cleared flag, the detail encoding and a clean recovery on the next run. Timing-sensitive behaviour is covered by sample streams of varying density. These are a fixed 1-in-4 pattern, which gives a reproducible latency so that ignored mid-run triggers can be compared against it, and seeded random streams at two densities.

// File: rtl/bist_seq_pkg.sv
package bist_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RAM   = 3'd1,
    ST_FILT  = 3'd2,
    ST_XFRM  = 3'd3,
    ST_ARITH = 3'd4,
    ST_ADC   = 3'd5
  } stage_e;
  localparam int NUM_TESTS = 5;
  localparam logic [4:0] SUB_MISMATCH = 5'd1;
  localparam logic [4:0] SUB_TIMEOUT  = 5'd2;
endpackage

// File: rtl/bist_ram_chk.sv
module bist_ram_chk #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  output logic done_o,
  output logic pass_o
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    logic [DW-1:0] p;
    for (int i = 0; i < DW; i++) p[i] = a[i % AW] ^ i[0];
    return p;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] addr_q;
  logic wr_q, rd_q, ok_q;

  always_ff @(posedge clk_i) begin
    if (wr_q) mem[addr_q] <= pat(addr_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
      ok_q   <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (go_i) begin
        wr_q   <= 1'b1;
        addr_q <= '0;
        ok_q   <= 1'b1;
      end else if (wr_q) begin
        if (addr_q == LAST) begin
          wr_q <= 1'b0;
          rd_q <= 1'b1;
        end
        addr_q <= addr_q + 1'b1;
      end else if (rd_q) begin
        if (mem[addr_q] != pat(addr_q)) ok_q <= 1'b0;
        if (addr_q == LAST) begin
          rd_q   <= 1'b0;
          done_o <= 1'b1;
        end
        addr_q <= addr_q + 1'b1;
      end
    end
  end

  assign pass_o = ok_q;
endmodule

// File: rtl/bist_kat.sv
module bist_kat #(
  parameter int KIND  = 0,
  parameter int DW    = 16,
  parameter int STEPS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  output logic done_o,
  output logic pass_o
);
  localparam int SW = $clog2(STEPS + 1);
  localparam logic [DW-1:0] A0 = DW'(100);
  localparam logic [DW-1:0] B0 = DW'(30);

  function automatic logic [DW-1:0] golden(input int kind);
    logic [DW-1:0] acc, a, b, t, h0, h1, h2, h3;
    acc = '0; a = A0; b = B0; h0 = '0; h1 = '0; h2 = '0; h3 = '0;
    for (int k = 0; k < STEPS; k++) begin
      if (kind == 0) begin
        acc = acc + DW'(k + 1);
        h3 = h2; h2 = h1; h1 = h0; h0 = acc;
      end else if (kind == 1) begin
        t = a + b; b = a - b; a = t;
      end else begin
        acc = acc + DW'(k * (k + 3));
      end
    end
    if (kind == 0) return h0 - h3;
    if (kind == 1) return a ^ b;
    return acc;
  endfunction

  localparam logic [DW-1:0] GOLD = golden(KIND);

  logic run_q, chk_q, ok_q;
  logic [SW-1:0] step_q;
  logic [DW-1:0] k_dw, res;
  assign k_dw = DW'(step_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0; chk_q <= 1'b0; step_q <= '0; done_o <= 1'b0; ok_q <= 1'b0;
    end else begin
      done_o <= 1'b0;
      chk_q  <= 1'b0;
      if (go_i) begin
        run_q <= 1'b1; step_q <= '0;
      end else if (run_q) begin
        step_q <= step_q + 1'b1;
        if (step_q == SW'(STEPS - 1)) begin
          run_q <= 1'b0; chk_q <= 1'b1;
        end
      end
      if (chk_q) begin
        done_o <= 1'b1;
        ok_q   <= (res == GOLD);
      end
    end
  end

  assign pass_o = ok_q;

  if (KIND == 0) begin : g_intcomb
    logic [DW-1:0] acc_q, h0_q, h1_q, h2_q, h3_q, acc_n;
    assign acc_n = acc_q + k_dw + DW'(1);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        acc_q <= '0; h0_q <= '0; h1_q <= '0; h2_q <= '0; h3_q <= '0;
      end else if (go_i) begin
        acc_q <= '0; h0_q <= '0; h1_q <= '0; h2_q <= '0; h3_q <= '0;
      end else if (run_q) begin
        acc_q <= acc_n;
        h0_q <= acc_n; h1_q <= h0_q; h2_q <= h1_q; h3_q <= h2_q;
      end
    end
    assign res = h0_q - h3_q;  // comb stage, delay of three
  end else if (KIND == 1) begin : g_bfly
    logic [DW-1:0] a_q, b_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        a_q <= '0; b_q <= '0;
      end else if (go_i) begin
        a_q <= A0; b_q <= B0;
      end else if (run_q) begin
        a_q <= a_q + b_q; b_q <= a_q - b_q;
      end
    end
    assign res = a_q ^ b_q;
  end else begin : g_mac
    logic [DW-1:0] acc_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) acc_q <= '0;
      else if (go_i) acc_q <= '0;
      else if (run_q) acc_q <= acc_q + k_dw * (k_dw + DW'(3));
    end
    assign res = acc_q;
  end
endmodule

// File: rtl/bist_adc_cap.sv
module bist_adc_cap #(
  parameter int DW    = 16,
  parameter int CAP_N = 256,
  parameter int TMO   = 4096
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [DW-1:0] adc_data_i,
  input  logic          adc_valid_i,
  output logic          active_o,
  output logic [DW-1:0] cap_data_o,
  output logic          cap_valid_o,
  output logic          done_o,
  output logic          pass_o
);
  localparam int CW = $clog2(CAP_N + 1);
  localparam int TW = $clog2(TMO + 1);

  logic [CW-1:0] cnt_q;
  logic [TW-1:0] tmr_q;

  assign cap_valid_o = active_o & adc_valid_i;
  assign cap_data_o  = adc_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0; cnt_q <= '0; tmr_q <= '0; done_o <= 1'b0; pass_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (go_i) begin
        active_o <= 1'b1; cnt_q <= '0; tmr_q <= '0;
      end else if (active_o) begin
        tmr_q <= tmr_q + 1'b1;
        if (cap_valid_o) cnt_q <= cnt_q + 1'b1;
        if (cap_valid_o && cnt_q == CW'(CAP_N - 1)) begin
          active_o <= 1'b0; done_o <= 1'b1; pass_o <= 1'b1;
        end else if (tmr_q == TW'(TMO - 1)) begin
          active_o <= 1'b0; done_o <= 1'b1; pass_o <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/bist_sequencer.sv
module bist_sequencer
  import bist_seq_pkg::*;
#(
  parameter int RAM_AW    = 6,
  parameter int KAT_STEPS = 8,
  parameter int ADC_W     = 16,
  parameter int CAP_N     = 256,
  parameter int ADC_TMO   = 4096
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trigger_i,
  output logic             busy_o,
  output logic             result_valid_o,
  output logic [4:0]       result_flags_o,
  output logic [7:0]       result_detail_o,
  input  logic [ADC_W-1:0] adc_data_i,
  input  logic             adc_valid_i,
  output logic             capture_active_o,
  output logic [ADC_W-1:0] capture_data_o,
  output logic             capture_valid_o
);
  stage_e stage_q;
  logic go_q, rv_q, fail_seen_q;
  logic [NUM_TESTS-1:0] sel, go_vec, done_vec, pass_vec, flags_q;
  logic [7:0] detail_q;
  logic cur_done, cur_pass;
  logic [2:0] idx;

  always_comb begin
    for (int i = 0; i < NUM_TESTS; i++) sel[i] = (3'(stage_q) == 3'(i + 1));
  end
  assign go_vec   = sel & {NUM_TESTS{go_q}};
  assign cur_done = |(done_vec & sel);
  assign cur_pass = |(pass_vec & sel);
  assign idx      = 3'(stage_q) - 3'd1;

  bist_ram_chk #(.AW(RAM_AW), .DW(ADC_W)) i_ram (
    .clk_i, .rst_ni, .go_i(go_vec[0]), .done_o(done_vec[0]), .pass_o(pass_vec[0])
  );

  for (genvar g = 0; g < 3; g++) begin : g_kat
    bist_kat #(.KIND(g), .DW(ADC_W), .STEPS(KAT_STEPS)) i_kat (
      .clk_i, .rst_ni, .go_i(go_vec[g+1]), .done_o(done_vec[g+1]), .pass_o(pass_vec[g+1])
    );
  end

  bist_adc_cap #(.DW(ADC_W), .CAP_N(CAP_N), .TMO(ADC_TMO)) i_adc (
    .clk_i, .rst_ni, .go_i(go_vec[4]),
    .adc_data_i, .adc_valid_i,
    .active_o(capture_active_o), .cap_data_o(capture_data_o), .cap_valid_o(capture_valid_o),
    .done_o(done_vec[4]), .pass_o(pass_vec[4])
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= ST_IDLE; go_q <= 1'b0; rv_q <= 1'b0; fail_seen_q <= 1'b0;
      flags_q <= '0; detail_q <= '0;
    end else begin
      go_q <= 1'b0;
      if (stage_q == ST_IDLE) begin
        if (trigger_i) begin
          stage_q <= ST_RAM; go_q <= 1'b1; rv_q <= 1'b0;
          fail_seen_q <= 1'b0; flags_q <= '0; detail_q <= '0;
        end
      end else if (cur_done) begin
        if (cur_pass) flags_q <= flags_q | sel;
        else if (!fail_seen_q) begin
          fail_seen_q <= 1'b1;
          detail_q <= {idx, (stage_q == ST_ADC) ? SUB_TIMEOUT : SUB_MISMATCH};
        end
        if (stage_q == ST_ADC) begin
          stage_q <= ST_IDLE; rv_q <= 1'b1;
        end else begin
          stage_q <= stage_e'(3'(stage_q) + 3'd1); go_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o          = (stage_q != ST_IDLE);
  assign result_valid_o  = rv_q;
  assign result_flags_o  = flags_q;
  assign result_detail_o = detail_q;
endmodule

// File: rtl/bist_sequencer_chk.sv
module bist_sequencer_chk #(
  parameter int ADC_W = 16,
  parameter int CAP_N = 256
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             trigger_i,
  input logic             busy_o,
  input logic             result_valid_o,
  input logic [4:0]       result_flags_o,
  input logic [7:0]       result_detail_o,
  input logic [ADC_W-1:0] adc_data_i,
  input logic             adc_valid_i,
  input logic             capture_active_o,
  input logic [ADC_W-1:0] capture_data_o,
  input logic             capture_valid_o
);
  localparam int CW = $clog2(CAP_N + 1) + 1;
  logic [CW-1:0] cap_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cap_cnt_q <= '0;
    else if (trigger_i && !busy_o) cap_cnt_q <= '0;
    else if (capture_valid_o) cap_cnt_q <= cap_cnt_q + 1'b1;
  end

  // R2
  trig_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trigger_i && !busy_o) |=> busy_o);
  // R8
  done_rv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> result_valid_o);
  // R8
  rv_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> !busy_o);
  // R5
  fwd_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_valid_o |-> (capture_active_o && capture_data_o == adc_data_i && adc_valid_i));
  // R10
  cap_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_cnt_q <= CW'(CAP_N));
  // R3
  pass_detail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_valid_o && result_flags_o == 5'h1f) |-> result_detail_o == 8'h00);
  // R4
  adc_in_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_active_o |-> (busy_o && !result_valid_o));
endmodule

bind bist_sequencer bist_sequencer_chk #(.ADC_W(ADC_W), .CAP_N(CAP_N)) i_chk (.*);

// File: tb/test_bist_sequencer.sv
`timescale 1ns / 1ps
module test_bist_sequencer;
  localparam int RAM_AW = 6, KAT_STEPS = 8, CAP_N = 256, ADC_TMO = 4096;
  localparam int MIN_ADC_START = 2 * (1 << RAM_AW) + 3 * KAT_STEPS;

  logic clk = 1'b0, rst_n = 1'b0, trig = 1'b0;
  logic busy, rv, cap_act, cap_vld, adc_vld = 1'b0;
  logic [4:0] flags;
  logic [7:0] detail;
  logic [15:0] adc_data = '0, cap_data;

  int checks = 0, fails = 0, total_cyc = 0, ph = 0, mode = 0;

  always #5 clk = ~clk;

  bist_sequencer #(.RAM_AW(RAM_AW), .KAT_STEPS(KAT_STEPS), .CAP_N(CAP_N), .ADC_TMO(ADC_TMO))
  i_bist_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .trigger_i(trig), .busy_o(busy), .result_valid_o(rv),
    .result_flags_o(flags), .result_detail_o(detail), .adc_data_i(adc_data),
    .adc_valid_i(adc_vld), .capture_active_o(cap_act), .capture_data_o(cap_data),
    .capture_valid_o(cap_vld)
  );

  // ADC stimulus, updated shortly after each rising edge
  always @(posedge clk) begin
    #2;
    ph = ph + 1;
    adc_data = 16'(ph * 7 + 3);
    case (mode)
      1: adc_vld = (ph % 4 == 3);
      2: adc_vld = ($urandom % 3) == 0;
      3: adc_vld = ($urandom % 6) == 0;
      default: adc_vld = 1'b0;
    endcase
  end

  function automatic logic [4:0] exp_flags(input int m);
    return (m == 0) ? 5'b01111 : 5'b11111;
  endfunction
  function automatic logic [7:0] exp_detail(input int m);
    return (m == 0) ? {3'd4, 5'd2} : 8'h00;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  // one full run; returns latency, forwarded count, data mismatches, capture start cycle
  task automatic run_seq(input int m, input bit extra,
                         output int lat, output int caps, output int mism, output int rise);
    mode = m; lat = -1; caps = 0; mism = 0; rise = -1;
    @(negedge clk); ph = 0; trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    chk(busy === 1'b1, "R2 busy after trigger", busy, 1);
    chk(rv === 1'b0, "R8 result_valid cleared by trigger", rv, 0);
    for (int c = 1; c < 10000; c++) begin
      if (cap_vld) begin
        caps++;
        if (cap_data !== adc_data || !cap_act) mism++;
      end
      if (cap_act && rise < 0) rise = c;
      if (rv) begin lat = c; break; end
      trig = extra && (c == 50 || c == 300 || (rise > 0 && c == rise + 20));
      @(negedge clk);
    end
    trig = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      total_cyc++;
      if (total_cyc > 150000) begin
        chk(1'b0, "watchdog", total_cyc, 150000);
        finish_run();
      end
    end
  end

  initial begin
    int lat_a, lat_b, caps, mism, rise;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(busy === 1'b0, "R1 busy low", busy, 0);
    chk(rv === 1'b0, "R1 result_valid low", rv, 0);
    chk(flags === 5'b0 && detail === 8'h0, "R1 flags/detail zero", flags, 0);

    // healthy run, 1-in-4 samples
    run_seq(1, 1'b0, lat_a, caps, mism, rise);
    chk(flags === exp_flags(1), "R3 all flags", flags, exp_flags(1));
    chk(detail === exp_detail(1), "R3 detail zero", detail, exp_detail(1));
    chk(caps == CAP_N, "R5 forwarded count", caps, CAP_N);
    chk(mism == 0, "R5 forwarded data", mism, 0);
    chk(rise >= MIN_ADC_START, "R4 ADC stage last", rise, MIN_ADC_START);
    chk(rv === 1'b1 && busy === 1'b0, "R8 done handshake", {rv, busy}, 2);
    repeat (20) @(negedge clk);
    chk(cap_vld === 1'b0 && cap_act === 1'b0, "R10 no forwarding after burst", cap_vld, 0);

    // same stimulus with triggers while busy
    run_seq(1, 1'b1, lat_b, caps, mism, rise);
    chk(lat_b == lat_a, "R9 latency unchanged", lat_b, lat_a);
    chk(flags === exp_flags(1), "R9 flags unchanged", flags, exp_flags(1));
    chk(caps == CAP_N, "R10 exact burst length", caps, CAP_N);

    // random sparse streams
    for (int d = 2; d <= 3; d++) begin
      run_seq(d, 1'b0, lat_b, caps, mism, rise);
      chk(flags === exp_flags(d), "R6 sparse flags", flags, exp_flags(d));
      chk(caps == CAP_N && mism == 0, "R6 sparse capture", caps, CAP_N);
    end

    // silent ADC
    run_seq(0, 1'b0, lat_b, caps, mism, rise);
    chk(flags === exp_flags(0), "R7 timeout flags", flags, exp_flags(0));
    chk(detail === exp_detail(0), "R7 timeout detail", detail, exp_detail(0));
    chk(caps == 0 && cap_act === 1'b0, "R7 nothing forwarded", caps, 0);

    // recovery and repeat
    run_seq(1, 1'b0, lat_b, caps, mism, rise);
    chk(flags === exp_flags(1) && detail === 8'h0, "R8 rerun results", flags, exp_flags(1));
    chk(lat_b == lat_a, "R8 rerun latency", lat_b, lat_a);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule